// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers interrupt requests from network slots into two 16-bit status words and drives a single combined interrupt line toward the CPU. A status bit reads 0 while its request is pending and 1 while it is idle. Every request names a slot and a port. A fixed map turns that pair into one bit of one status word. Slot 0 uses the first word. Slots 1 to 4 share the second word, each from its own base bit. The bit used is always the base plus the port.

Hardware sources raise a request with a set strobe and withdraw it with a clear strobe. The two strobe channels are independent, so one request can be raised and a different one withdrawn in the same cycle. A small register bus reads both status words and reads or writes two 16-bit mask words. The masks are only stored for software. They do not gate the combined line.

Top module: `nirq_aggregator`

## Requirements
- R1: After a synchronous reset, both status words read 0xFFFF, both mask words read 0x0000, and `net_irq` is 0.
- R2: Slot 0 maps to status word 0 with base bit 0. Slots 1, 2, 3 and 4 map to status word 1 with base bits 0, 4, 8 and 12. The bit used is base + port.
- R3: A set strobe drives the mapped bit to 0 at the next clock edge. A clear strobe drives it back to 1. All other bits keep their value.
- R4: `net_irq` is a register. It is 1 in the cycle after either status word differs from 0xFFFF, and 0 in the cycle after both words are 0xFFFF.
- R5: If a set strobe and a clear strobe name the same bit in one cycle, the bit becomes 0.
- R6: A strobe with slot above 4, or with base + port above 15, changes no status bit.
- R7: Mask word 0 is at offset 0x2A and mask word 1 at 0x2C. Both can be read and written, and their values never affect `net_irq`.
- R8: Status word 0 reads at offset 0x20 and status word 1 at 0x22. A bus write to either offset changes nothing.
- R9: A read of any other offset, including odd offsets, returns 0x0000.
- R10: `bus_rdata` is registered. It shows the addressed value in the cycle after `bus_rd` is 1, and it holds that value while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Raise the request named by set_slot/set_port |
| set_slot | input | 3 | Slot index of the request to raise |
| set_port | input | 4 | Port index of the request to raise |
| clr_stb | input | 1 | Withdraw the request named by clr_slot/clr_port |
| clr_slot | input | 3 | Slot index of the request to withdraw |
| clr_port | input | 4 | Port index of the request to withdraw |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| net_irq | output | 1 | Combined interrupt, high while any request is pending |

## Verification
The assertions check these rules on every cycle:
- a valid raise shows on `net_irq` two cycles later;
- a raise wins over a withdraw of the same bit;
- out-of-range strobes leave an idle status untouched;
- status writes are dropped;
- mask writes are stored;
- undecoded reads give zero;
- read data holds between reads.

Only the bench scenarios show the exact bit that each slot and port reaches in each word. They also show that withdrawing the last request drops the line, and that a fully set mask leaves the line high.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NIRQ_REG_W     = 16;
  localparam int NIRQ_NREGS     = 2;
  localparam int NIRQ_NSLOTS    = 5;
  localparam int NIRQ_PORT_SPAN = 4;
  localparam int NIRQ_SLOT_W    = 3;
  localparam int NIRQ_PORT_W    = 4;
  localparam int NIRQ_ADDR_W    = 8;
  localparam int NIRQ_STAT_BASE = 'h20;
  localparam int NIRQ_MASK_BASE = 'h2A;

  // Status word that holds a given slot.
  function automatic int slot_word(input int slot);
    return (slot == 0) ? 0 : 1;
  endfunction

  // Base bit of a given slot inside its word.
  function automatic int slot_base(input int slot, input int span);
    return (slot == 0) ? 0 : (slot - 1) * span;
  endfunction
endpackage

// File: rtl/nirq_decode.sv
module nirq_decode #(
  parameter int REG_W     = 16,
  parameter int NREGS     = 2,
  parameter int NSLOTS    = 5,
  parameter int PORT_SPAN = 4,
  parameter int SLOT_W    = 3,
  parameter int PORT_W    = 4
) (
  input  logic                   en,
  input  logic [SLOT_W-1:0]      slot,
  input  logic [PORT_W-1:0]      port,
  output logic [NREGS*REG_W-1:0] hit
);
  import nirq_pkg::*;

  always_comb begin
    int s;
    int w;
    int pos;
    hit = '0;
    s   = int'(slot);
    w   = slot_word(s);
    pos = slot_base(s, PORT_SPAN) + int'(port);
    if (en && s < NSLOTS && w < NREGS && pos < REG_W)
      hit[w*REG_W + pos] = 1'b1;
  end
endmodule

// File: rtl/nirq_status.sv
module nirq_status #(
  parameter int REG_W = 16,
  parameter int NREGS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREGS*REG_W-1:0] set_hit,
  input  logic [NREGS*REG_W-1:0] clr_hit,
  output logic [NREGS*REG_W-1:0] stat
);
  for (genvar g = 0; g < NREGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        stat[g*REG_W +: REG_W] <= '1;
      else
        stat[g*REG_W +: REG_W] <= (stat[g*REG_W +: REG_W] | clr_hit[g*REG_W +: REG_W])
                                  & ~set_hit[g*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/nirq_regbus.sv
module nirq_regbus #(
  parameter int REG_W     = 16,
  parameter int NREGS     = 2,
  parameter int NMASK     = 2,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 'h20,
  parameter int MASK_BASE = 'h2A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [REG_W-1:0]       bus_wdata,
  input  logic [NREGS*REG_W-1:0] stat,
  output logic [NMASK*REG_W-1:0] mask,
  output logic [REG_W-1:0]       bus_rdata
);
  logic [REG_W-1:0] rd_mux;

  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(MASK_BASE + 2*g);
    always_ff @(posedge clk) begin
      if (rst)
        mask[g*REG_W +: REG_W] <= '0;
      else if (bus_wr && bus_addr == MADDR)
        mask[g*REG_W +: REG_W] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREGS; i++)
      if (bus_addr == ADDR_W'(STAT_BASE + 2*i)) rd_mux = stat[i*REG_W +: REG_W];
    for (int i = 0; i < NMASK; i++)
      if (bus_addr == ADDR_W'(MASK_BASE + 2*i)) rd_mux = mask[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator #(
  parameter int REG_W     = nirq_pkg::NIRQ_REG_W,
  parameter int NREGS     = nirq_pkg::NIRQ_NREGS,
  parameter int NSLOTS    = nirq_pkg::NIRQ_NSLOTS,
  parameter int PORT_SPAN = nirq_pkg::NIRQ_PORT_SPAN,
  parameter int SLOT_W    = nirq_pkg::NIRQ_SLOT_W,
  parameter int PORT_W    = nirq_pkg::NIRQ_PORT_W,
  parameter int ADDR_W    = nirq_pkg::NIRQ_ADDR_W,
  parameter int STAT_BASE = nirq_pkg::NIRQ_STAT_BASE,
  parameter int MASK_BASE = nirq_pkg::NIRQ_MASK_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [PORT_W-1:0] set_port,
  input  logic              clr_stb,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [PORT_W-1:0] clr_port,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              net_irq
);
  localparam int FLAT_W = NREGS * REG_W;
  localparam int NMASK  = 2;

  logic [FLAT_W-1:0]      set_hit;
  logic [FLAT_W-1:0]      clr_hit;
  logic [FLAT_W-1:0]      stat_flat;
  logic [NMASK*REG_W-1:0] mask_flat;

  nirq_decode #(.REG_W(REG_W), .NREGS(NREGS), .NSLOTS(NSLOTS), .PORT_SPAN(PORT_SPAN),
                .SLOT_W(SLOT_W), .PORT_W(PORT_W))
    u_dec_set (.en(set_stb), .slot(set_slot), .port(set_port), .hit(set_hit));

  nirq_decode #(.REG_W(REG_W), .NREGS(NREGS), .NSLOTS(NSLOTS), .PORT_SPAN(PORT_SPAN),
                .SLOT_W(SLOT_W), .PORT_W(PORT_W))
    u_dec_clr (.en(clr_stb), .slot(clr_slot), .port(clr_port), .hit(clr_hit));

  nirq_status #(.REG_W(REG_W), .NREGS(NREGS))
    u_stat (.clk(clk), .rst(rst), .set_hit(set_hit), .clr_hit(clr_hit), .stat(stat_flat));

  nirq_regbus #(.REG_W(REG_W), .NREGS(NREGS), .NMASK(NMASK), .ADDR_W(ADDR_W),
                .STAT_BASE(STAT_BASE), .MASK_BASE(MASK_BASE))
    u_bus (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
           .bus_wdata(bus_wdata), .stat(stat_flat), .mask(mask_flat), .bus_rdata(bus_rdata));

  always_ff @(posedge clk) begin
    if (rst) net_irq <= 1'b0;
    else     net_irq <= ~&stat_flat;
  end
endmodule

// File: rtl/nirq_aggregator_chk.sv
module nirq_aggregator_chk #(
  parameter int REG_W     = 16,
  parameter int NREGS     = 2,
  parameter int NSLOTS    = 5,
  parameter int PORT_SPAN = 4,
  parameter int SLOT_W    = 3,
  parameter int PORT_W    = 4,
  parameter int ADDR_W    = 8,
  parameter int STAT_BASE = 'h20,
  parameter int MASK_BASE = 'h2A
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   set_stb,
  input logic [SLOT_W-1:0]      set_slot,
  input logic [PORT_W-1:0]      set_port,
  input logic                   clr_stb,
  input logic [SLOT_W-1:0]      clr_slot,
  input logic [PORT_W-1:0]      clr_port,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [REG_W-1:0]       bus_wdata,
  input logic [REG_W-1:0]       bus_rdata,
  input logic                   net_irq,
  input logic [NREGS*REG_W-1:0] stat_flat,
  input logic [2*REG_W-1:0]     mask_flat
);
  logic set_ok;
  int   set_bit;
  logic addr_known;

  always_comb begin
    int s;
    int p;
    s       = int'(set_slot);
    p       = ((s == 0) ? 0 : (s - 1) * PORT_SPAN) + int'(set_port);
    set_ok  = set_stb && s < NSLOTS && p < REG_W;
    set_bit = ((s == 0) ? 0 : REG_W) + p;
    addr_known = 1'b0;
    for (int i = 0; i < NREGS; i++)
      if (int'(bus_addr) == STAT_BASE + 2*i) addr_known = 1'b1;
    for (int i = 0; i < 2; i++)
      if (int'(bus_addr) == MASK_BASE + 2*i) addr_known = 1'b1;
  end

  // R4
  set_reaches_irq_chk: assert property (@(posedge clk) disable iff (rst)
    set_ok |=> ##1 net_irq);

  // R5
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (set_ok && clr_stb && clr_slot == set_slot && clr_port == set_port)
      |=> !stat_flat[$past(set_bit)]);

  // R6
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (set_stb && !set_ok && !clr_stb && (&stat_flat)) |=> (&stat_flat));

  // R8
  stat_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == STAT_BASE && !set_stb && !clr_stb) |=> $stable(stat_flat));

  // R7
  mask_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == MASK_BASE) |=> mask_flat[REG_W-1:0] == $past(bus_wdata));

  // R9
  undecoded_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !addr_known) |=> bus_rdata == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind nirq_aggregator nirq_aggregator_chk #(
  .REG_W(REG_W), .NREGS(NREGS), .NSLOTS(NSLOTS), .PORT_SPAN(PORT_SPAN),
  .SLOT_W(SLOT_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
  .STAT_BASE(STAT_BASE), .MASK_BASE(MASK_BASE)
) u_chk (.*);

// File: tb/sim_nirq_aggregator.sv
`timescale 1ns/1ps
module sim_nirq_aggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_stb = 1'b0, clr_stb = 1'b0;
  logic [2:0]  set_slot = '0, clr_slot = '0;
  logic [3:0]  set_port = '0, clr_port = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        net_irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_stat [2];
  logic [15:0] m_mask [2];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] last_rd;

  always #4 clk = ~clk;

  nirq_aggregator u0 (.clk(clk), .rst(rst), .set_stb(set_stb), .set_slot(set_slot),
    .set_port(set_port), .clr_stb(clr_stb), .clr_slot(clr_slot), .clr_port(clr_port),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .net_irq(net_irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data one edge after the read strobe.
  always @(posedge clk) begin
    logic was_rd;
    was_rd = bus_rd;
    #2;
    if (was_rd && exp_q.size() > 0) begin
      last_rd = exp_q.pop_front();
      check(tag_q.pop_front(), bus_rdata, last_rd);
    end
  end

  function automatic int map_pos(input int slot, input int port, output int word);
    word = (slot == 0) ? 0 : 1;
    if (slot > 4) return -1;
    map_pos = ((slot == 0) ? 0 : 4 * (slot - 1)) + port;
    if (map_pos > 15) map_pos = -1;
  endfunction

  function automatic logic [15:0] m_read(input logic [7:0] a);
    case (a)
      8'h20: return m_stat[0];
      8'h22: return m_stat[1];
      8'h2A: return m_mask[0];
      8'h2C: return m_mask[1];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic strobe(input logic se, input int ss, input int sp,
                        input logic ce, input int cs, input int cp, input string tag);
    int w, pos;
    @(negedge clk);
    set_stb = se; set_slot = 3'(ss); set_port = 4'(sp);
    clr_stb = ce; clr_slot = 3'(cs); clr_port = 4'(cp);
    @(negedge clk);
    set_stb = 1'b0; clr_stb = 1'b0;
    if (ce) begin pos = map_pos(cs, cp, w); if (pos >= 0) m_stat[w][pos] = 1'b1; end
    if (se) begin pos = map_pos(ss, sp, w); if (pos >= 0) m_stat[w][pos] = 1'b0; end
    @(negedge clk);
    check({tag, " R4 net_irq"}, {15'd0, net_irq},
          {15'd0, (m_stat[0] != 16'hFFFF) || (m_stat[1] != 16'hFFFF)});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(m_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h2A) m_mask[0] = d;
    if (a == 8'h2C) m_mask[1] = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_stat[0] = 16'hFFFF; m_stat[1] = 16'hFFFF;
    m_mask[0] = 16'h0000; m_mask[1] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 net_irq", {15'd0, net_irq}, 16'h0000);
    rd(8'h20, "R1 stat0"); rd(8'h22, "R1 stat1");
    rd(8'h2A, "R1 mask0"); rd(8'h2C, "R1 mask1");
    // R2 R3 mapping
    strobe(1, 0, 3, 0, 0, 0, "R2 s0p3");
    rd(8'h20, "R2 stat0 bit3");
    strobe(1, 2, 1, 0, 0, 0, "R2 s2p1");
    strobe(1, 4, 3, 0, 0, 0, "R2 s4p3");
    strobe(1, 3, 0, 0, 0, 0, "R2 s3p0");
    rd(8'h22, "R2 stat1 bits");
    strobe(1, 0, 15, 0, 0, 0, "R2 s0p15");
    rd(8'h20, "R2 stat0 bit15");
    // R3 clear and R10 hold
    strobe(0, 0, 0, 1, 0, 3, "R3 clr s0p3");
    rd(8'h20, "R3 stat0");
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, last_rd);
    // R7 masks do not gate the line
    wr(8'h2A, 16'hFFFF); wr(8'h2C, 16'hA55A);
    rd(8'h2A, "R7 mask0"); rd(8'h2C, "R7 mask1");
    check("R7 irq not masked", {15'd0, net_irq}, 16'h0001);
    // R8 status writes dropped
    wr(8'h20, 16'h0000); wr(8'h22, 16'hFFFF);
    rd(8'h20, "R8 stat0"); rd(8'h22, "R8 stat1");
    // R4 clear everything: line drops
    strobe(0, 0, 0, 1, 0, 15, "R4 clr s0p15");
    strobe(0, 0, 0, 1, 2, 1, "R4 clr s2p1");
    strobe(0, 0, 0, 1, 4, 3, "R4 clr s4p3");
    strobe(0, 0, 0, 1, 3, 0, "R4 clr last");
    rd(8'h22, "R4 stat1 idle");
    // R5 same bit: set wins
    strobe(1, 1, 2, 1, 1, 2, "R5 same bit");
    rd(8'h22, "R5 stat1");
    // set one, clear another in the same cycle
    strobe(1, 0, 0, 1, 1, 2, "R3 mixed");
    rd(8'h20, "R3 mixed stat0"); rd(8'h22, "R3 mixed stat1");
    strobe(0, 0, 0, 1, 0, 0, "R4 idle again");
    // R6 out of range
    strobe(1, 5, 0, 0, 0, 0, "R6 slot5");
    strobe(1, 7, 2, 0, 0, 0, "R6 slot7");
    strobe(1, 4, 4, 0, 0, 0, "R6 pos16");
    rd(8'h20, "R6 stat0"); rd(8'h22, "R6 stat1");
    // R9 undecoded
    rd(8'h24, "R9 0x24"); rd(8'h21, "R9 0x21"); rd(8'h00, "R9 0x00");
    rd(8'h2E, "R9 0x2E");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule